// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Register

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide register bus. Software programs three registers. The output latch holds the value each pin drives. The direction register selects, pin by pin, whether the output driver is enabled. The pull-up control register requests a weak pull-up on pins that are inputs. The block drives output data, output enable and pull-up enable vectors toward the pad ring, and it takes the sensed pin levels back through a two-flop synchronizer.

A read of the data offset returns a per-bit mix. A bit whose direction is output returns the latch value. A bit whose direction is input returns the synchronized pin level. The latch accepts writes whatever the direction bits hold. Software can therefore load a safe level first and then turn the driver on, and the pin goes straight to that level. Read data is registered and appears one cycle after the read strobe. It then holds until the next strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, latch and pull-up registers are 0x00, and `padOe`, `padOut`, `padPullEn` and `busRdData` are all 0x00. Every pin therefore starts as an input.
- R2: The direction register is at offset 0x4. A write sets `padOe` to the written byte on the same clock edge, where bit n equal to 1 enables pin n's driver. A read of offset 0x4 returns the stored byte.
- R3: A write to offset 0x0 updates the output latch whatever the direction bits hold. `padOut` equals the latch from the same clock edge.
- R4: A read of offset 0x0 returns, for each bit n, the latch bit if direction bit n is 1 and the synchronized level of `padIn[n]` if it is 0.
- R5: Pin levels pass through two flops. A read strobe sampled at the first or second rising edge after a change on `padIn` returns the old level. A strobe sampled at the third edge returns the new level.
- R6: `busRdData` is loaded on the rising edge that samples `busRdEn` high. It keeps its value while `busRdEn` is low, even if registers or pins change.
- R7: The pull-up register is at offset 0x8 and reads back its stored byte. `padPullEn[n]` is pull-up bit n AND NOT direction bit n.
- R8: A read of any offset other than 0x0, 0x4 or 0x8 returns 0x00. A write to such an offset changes no register and no pad output.
- R9: Suppose a latch value is written while a pin is an input, and the direction bit is then set to 1. `padOut` already holds that value on the edge where `padOe` rises and does not change on that edge.
- R10: A read and a write to the same offset in the same cycle return the register value from before the write. A later read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data, valid the cycle after the strobe |
| padIn | input | 8 | Sensed pin levels, asynchronous |
| padOut | output | 8 | Output data toward the pads |
| padOe | output | 8 | Per-pin output driver enable |
| padPullEn | output | 8 | Per-pin pull-up enable, only for input pins |

## Verification
Two operations can meet on the same clock edge: a register write and a read of the same register. The bench provokes this by raising both strobes in one cycle on the direction offset. It expects the returned byte to be the value from before the write, and a following read to show the new value. A second case of the same kind sets a direction bit to 1 in the cycle after the latch was preloaded. The bench checks that the latch value is on `padOut` on the edge where the driver turns on, and that the latch does not change on that edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    RD_DATA = 2'd0,
    RD_DIR  = 2'd1,
    RD_PULL = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrPull;
    logic   rdEn;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h0,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 'h4,
  parameter logic [ADDR_W-1:0] PULL_OFS = 'h8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobe_t        strobe
);

  logic hitData;
  logic hitDir;
  logic hitPull;

  assign hitData = (busAddr == DATA_OFS);
  assign hitDir  = (busAddr == DIR_OFS);
  assign hitPull = (busAddr == PULL_OFS);

  always_comb begin
    strobe.wrData = busWrEn && hitData;
    strobe.wrDir  = busWrEn && hitDir;
    strobe.wrPull = busWrEn && hitPull;
    strobe.rdEn   = busRdEn;
    if (hitData)      strobe.rdSel = RD_DATA;
    else if (hitDir)  strobe.rdSel = RD_DIR;
    else if (hitPull) strobe.rdSel = RD_PULL;
    else              strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPullEn
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] pullQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinLevel;
  logic [WIDTH-1:0] mixedData;
  logic [WIDTH-1:0] readNext;

  // Control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
      pullQ  <= '0;
    end else begin
      if (strobe.wrData) latchQ <= wrData;
      if (strobe.wrDir)  dirQ   <= wrData;
      if (strobe.wrPull) pullQ  <= wrData;
    end
  end

  // Pin synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncQ[LAST_STAGE];

  // Per-bit read mix: driven pins report the latch, input pins the pin
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_mix
      assign mixedData[b] = dirQ[b] ? latchQ[b] : pinLevel[b];
    end
  endgenerate

  always_comb begin
    case (strobe.rdSel)
      RD_DATA: readNext = mixedData;
      RD_DIR:  readNext = dirQ;
      RD_PULL: readNext = pullQ;
      default: readNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= readNext;
  end

  assign padOut    = latchQ;
  assign padOe     = dirQ;
  assign padPullEn = pullQ & ~dirQ;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> padOe == $past(wrData));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> padOut == $past(wrData));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData));

  // R9
  preload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrDir && !strobe.wrData) |=> padOut == $past(padOut));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h0,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 'h4,
  parameter logic [ADDR_W-1:0] PULL_OFS = 'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPullEn
);

  busStrobe_t strobe;

  gpio_port_ctrl #(
    .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe)
  );

  gpio_port_dp #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .padIn    (padIn),
    .rdData   (busRdData),
    .padOut   (padOut),
    .padOe    (padOe),
    .padPullEn(padPullEn)
  );

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != DATA_OFS && busAddr != DIR_OFS && busAddr != PULL_OFS)
    |=> ($stable(padOut) && $stable(padOe) && $stable(padPullEn)));

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic [7:0] padIn = '0;
  logic [7:0] padOut;
  logic [7:0] padOe;
  logic [7:0] padPullEn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic settlePins(input logic [7:0] v);
    @(negedge clk);
    padIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    check("R1 padPullEn", padPullEn, 8'h00);
    check("R1 busRdData", busRdData, 8'h00);
    busRead(4'h4, d); check("R1 dir read", d, 8'h00);
    busRead(4'h8, d); check("R1 pull read", d, 8'h00);
  endtask

  task automatic testLatchDir();
    logic [7:0] d;
    busWrite(4'h0, 8'h3C);
    check("R3 padOut while input", padOut, 8'h3C);
    check("R3 padOe unchanged", padOe, 8'h00);
    busWrite(4'h4, 8'hF0);
    check("R2 padOe", padOe, 8'hF0);
    busRead(4'h4, d); check("R2 dir read", d, 8'hF0);
  endtask

  task automatic testMix();
    logic [7:0] d;
    settlePins(8'h5A);
    busRead(4'h0, d); check("R4 mix dir F0", d, 8'h3A);
    busWrite(4'h4, 8'h0F);
    busRead(4'h0, d); check("R4 mix dir 0F", d, 8'h5C);
    busWrite(4'h4, 8'h00);
    busRead(4'h0, d); check("R4 all inputs", d, 8'h5A);
  endtask

  task automatic testSync();
    // direction all inputs, pins 0x5A -> 0xC3
    @(negedge clk);
    padIn = 8'hC3;
    @(negedge clk);            // first edge after change has passed
    busAddr = 4'h0; busRdEn = 1'b1;
    @(negedge clk);            // strobe sampled at second edge
    check("R5 second edge old", busRdData, 8'h5A);
    @(negedge clk);            // strobe sampled at third edge
    check("R5 third edge new", busRdData, 8'hC3);
    busRdEn = 1'b0;
  endtask

  task automatic testHold();
    busWrite(4'h4, 8'hAA);
    settlePins(8'h11);
    check("R6 hold without strobe", busRdData, 8'hC3);
  endtask

  task automatic testPull();
    logic [7:0] d;
    busWrite(4'h4, 8'h0F);
    busWrite(4'h8, 8'hFF);
    check("R7 pull masked", padPullEn, 8'hF0);
    busRead(4'h8, d); check("R7 pull read", d, 8'hFF);
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    busWrite(4'h2, 8'h77);
    busWrite(4'hC, 8'h55);
    check("R8 padOut kept", padOut, 8'h3C);
    check("R8 padOe kept", padOe, 8'h0F);
    check("R8 padPullEn kept", padPullEn, 8'hF0);
    busRead(4'h4, d); check("R8 dir kept", d, 8'h0F);
    busRead(4'h2, d); check("R8 unmapped read 2", d, 8'h00);
    busRead(4'h4, d);
    busRead(4'hC, d); check("R8 unmapped read C", d, 8'h00);
  endtask

  task automatic testPreload();
    busWrite(4'h4, 8'h00);
    busWrite(4'h0, 8'h96);
    check("R9 preload latch", padOut, 8'h96);
    @(negedge clk);
    busAddr = 4'h4; busWrData = 8'hFF; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    check("R9 oe rises", padOe, 8'hFF);
    check("R9 out at rise", padOut, 8'h96);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic testSameCycle();
    logic [7:0] d;
    @(negedge clk);
    busAddr = 4'h4; busWrData = 8'h81; busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check("R10 read old", busRdData, 8'hFF);
    busRead(4'h4, d); check("R10 read new", d, 8'h81);
  endtask

  initial begin
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatchDir();
    testMix();
    testSync();
    testHold();
    testPull();
    testUnmapped();
    testPreload();
    testSameCycle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule